// File: doc/BRIEF.md
# Dual-Port Two-Word Burst Quad-Data-Rate SRAM

This block is a synthesizable model of a synchronous SRAM with a separate write data input and read data output. The two data ports share one address bus and work independently of each other. Each address location holds a pair of words. Every access moves that pair as a two-word burst, one word per clock edge. A read and a write can both be in progress in the same clock period.

The block runs from one edge clock, `clk`. Its rising edges alternate between the two edge kinds of a complementary clock pair. After reset, the first edge is a K edge, the next is a K-bar edge, and the pattern repeats. One K edge and the K-bar edge after it make up one cycle.

- On a K edge, the block samples the read select and, when it is set, captures the read address.
- On the same K edge, it samples the write select and, when it is set, captures the first write word.
- On the K-bar edge that follows an accepted write, it captures the write address and the second write word.

Read data comes out two full cycles after the read address was captured. Echo clocks run alongside the read data. A write that has not yet reached the array is held in a one-entry late-write buffer, and a read that hits that buffer returns the buffered data.

Top module: `qdr_burst_sram`

## Requirements
- R1: While `rst_n` is low, `rd_valid` and `rd_data` are 0, `cq` is 0 and `cq_n` is 1. The first `clk` edge after reset is a K edge, and edges then alternate K, K-bar.
- R2: When `wr_sel` is high on a K edge, `wr_data` is taken as word 0. On the following K-bar edge, `addr` is taken as the write address and `wr_data` as word 1.
- R3: When `rd_sel` is high on a K edge, `addr` on that edge is taken as the read address. `rd_sel` is ignored on K-bar edges.
- R4: For a read captured on edge n, word 0 appears on `rd_data` after edge n+4, which is two cycles later.
- R5: Word 1 of the burst follows on the very next edge (n+5). Word 0 always comes out before word 1, and the pair belongs to one address.
- R6: A read and a write in the same cycle are both carried out. If they name the same address, the read returns the data that was there before that write, because the write address is captured after the read address.
- R7: A read whose address matches a write still held in the late-write buffer returns the new write data, not the array contents.
- R8: `rd_valid` is high exactly on the two edges that carry burst words. On every other edge, `rd_valid` is low and `rd_data` keeps its last value.
- R9: `cq` is 1 after each K edge and 0 after each K-bar edge. `cq_n` is always its complement.
- R10: A cycle with `wr_sel` low leaves memory unchanged, whatever is on `addr` and `wr_data`.
- R11: Reads accepted on consecutive cycles produce an unbroken stream of bursts with `rd_valid` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Edge clock. Its rising edges alternate between K and K-bar edges. |
| rst_n | input | 1 | Active-low synchronous reset. |
| addr | input | ADDR_W | Shared address bus: the read address on K edges, the write address on K-bar edges. |
| rd_sel | input | 1 | Read select, sampled on K edges. |
| wr_sel | input | 1 | Write select, sampled on K edges. |
| wr_data | input | WORD_W | Write data: word 0 on the K edge, word 1 on the K-bar edge. |
| rd_data | output | WORD_W | Read data, one burst word per edge. |
| rd_valid | output | 1 | High while `rd_data` carries a burst word. |
| cq | output | 1 | Echo clock, high after K edges. |
| cq_n | output | 1 | Complementary echo clock. |

## Verification
The bench targets the following corner cases; each entry gives the case and the failure a faulty design would show.

- **Read immediately after a write to the same address.** The write is still in the late-write buffer. A design without forwarding returns stale array data.
- **Read and write to one address in the same cycle.** The read must return the old value. A design that forwards too eagerly returns the new value.
- **Write with the select low.** Garbage is driven on `addr` and `wr_data`. A design that does not gate on the select corrupts the location.
- **Consecutive writes to one address.** A design that commits the buffer in the wrong order loses the newer data.
- **Back-to-back reads.** These expose off-by-one latency, swapped burst words, gaps in `rd_valid`, and echo clocks that are out of step with the data.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    typedef enum logic {
        PH_K  = 1'b0,
        PH_KN = 1'b1
    } phase_e;
endpackage

// File: rtl/qdr_mem_array.sv
module qdr_mem_array #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     waddr,
    input  logic [2*WORD_W-1:0]   wdata,
    input  logic [ADDR_W-1:0]     raddr,
    output logic [2*WORD_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [2*WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/qdr_wr_path.sv
module qdr_wr_path #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  k_tick,
    input  logic                  wr_sel,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wr_data,
    output logic                  commit_en,
    output logic [ADDR_W-1:0]     commit_addr,
    output logic [2*WORD_W-1:0]   commit_data,
    output logic                  pend_v,
    output logic [ADDR_W-1:0]     pend_addr,
    output logic [2*WORD_W-1:0]   pend_data
);
    typedef struct packed {
        logic                beat;
        logic [WORD_W-1:0]   w0;
        logic                pv;
        logic [ADDR_W-1:0]   pa;
        logic [2*WORD_W-1:0] pd;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        commit_en = 1'b0;
        if (k_tick) begin
            st_d.beat = wr_sel;
            if (wr_sel) st_d.w0 = wr_data;
        end else begin
            st_d.beat = 1'b0;
            if (st_q.beat) begin
                commit_en = st_q.pv;
                st_d.pv   = 1'b1;
                st_d.pa   = addr;
                st_d.pd   = {wr_data, st_q.w0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_addr = st_q.pa;
    assign commit_data = st_q.pd;
    assign pend_v      = st_q.pv;
    assign pend_addr   = st_q.pa;
    assign pend_data   = st_q.pd;

    AST_PEND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.beat && !k_tick) |=> (pend_v && pend_addr == $past(addr)
                                    && pend_data[2*WORD_W-1:WORD_W] == $past(wr_data))); // R2
    AST_NO_BEAT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.beat && !k_tick) |=> $stable(pend_data)); // R10
endmodule

// File: rtl/qdr_rd_path.sv
module qdr_rd_path #(
    parameter int WORD_W  = 18,
    parameter int LAT_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  k_tick,
    input  logic                  rd_take,
    input  logic [2*WORD_W-1:0]   lookup,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic                  cq,
    output logic                  cq_n
);
    localparam int DEPTH = 2 * LAT_CYC + 1;

    typedef struct packed {
        logic                v;
        logic [2*WORD_W-1:0] d;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0]   pipe;
        logic [WORD_W-1:0]   dout;
        logic                dv;
        logic                cq;
        logic                cqn;
    } rst_t;

    rst_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.pipe[0].v = rd_take;
        st_d.pipe[0].d = lookup;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        if (k_tick) begin
            st_d.cq  = 1'b1;
            st_d.cqn = 1'b0;
            st_d.dv  = st_q.pipe[DEPTH-2].v;
            if (st_q.pipe[DEPTH-2].v) st_d.dout = st_q.pipe[DEPTH-2].d[WORD_W-1:0];
        end else begin
            st_d.cq  = 1'b0;
            st_d.cqn = 1'b1;
            st_d.dv  = st_q.pipe[DEPTH-1].v;
            if (st_q.pipe[DEPTH-1].v) st_d.dout = st_q.pipe[DEPTH-1].d[2*WORD_W-1:WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cqn <= 1'b1;
        end else begin
            st_q     <= st_d;
        end
    end

    assign rd_data  = st_q.dout;
    assign rd_valid = st_q.dv;
    assign cq       = st_q.cq;
    assign cq_n     = st_q.cqn;

    AST_ECHO_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        cq_n == !cq); // R9
    AST_ECHO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cq != $past(cq)); // R9
    AST_BURST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && cq) |=> (rd_valid && !cq)); // R5
    AST_NO_LONE_WORD1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !cq) |-> $past(rd_valid && cq)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data)); // R8
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18,
    parameter int RD_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                rd_sel,
    input  logic                wr_sel,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic                cq,
    output logic                cq_n
);
    import qdr_pkg::*;

    localparam int PAIR_W = 2 * WORD_W;

    typedef struct packed {
        phase_e ph;
    } top_t;

    top_t st_d, st_q;
    logic k_tick;

    always_comb begin
        st_d    = st_q;
        st_d.ph = (st_q.ph == PH_K) ? PH_KN : PH_K;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_K};
        else        st_q <= st_d;
    end

    assign k_tick = (st_q.ph == PH_K);

    logic                commit_en, pend_v;
    logic [ADDR_W-1:0]   commit_addr, pend_addr;
    logic [PAIR_W-1:0]   commit_data, pend_data, mem_rdata, lookup;

    qdr_wr_path #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_wr (
        .clk(clk), .rst_n(rst_n), .k_tick(k_tick), .wr_sel(wr_sel),
        .addr(addr), .wr_data(wr_data),
        .commit_en(commit_en), .commit_addr(commit_addr), .commit_data(commit_data),
        .pend_v(pend_v), .pend_addr(pend_addr), .pend_data(pend_data)
    );

    qdr_mem_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_mem (
        .clk(clk), .we(commit_en), .waddr(commit_addr), .wdata(commit_data),
        .raddr(addr), .rdata(mem_rdata)
    );

    assign lookup = (pend_v && pend_addr == addr) ? pend_data : mem_rdata;

    qdr_rd_path #(.WORD_W(WORD_W), .LAT_CYC(RD_LAT)) i_rd (
        .clk(clk), .rst_n(rst_n), .k_tick(k_tick), .rd_take(rd_sel && k_tick),
        .lookup(lookup), .rd_data(rd_data), .rd_valid(rd_valid),
        .cq(cq), .cq_n(cq_n)
    );

    AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> st_q.ph != $past(st_q.ph)); // R1
    AST_COMMIT_ON_KN: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> !k_tick); // R2
    AST_FWD_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (k_tick && rd_sel && pend_v && pend_addr == addr) |-> lookup == pend_data); // R7
endmodule

// File: tb/test_qdr_burst_sram.sv
module test_qdr_burst_sram;
    localparam int AW = 8;
    localparam int WW = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic rd_sel = 1'b0, wr_sel = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic [WW-1:0] rd_data;
    logic rd_valid, cq, cq_n;

    always #10 clk = ~clk;

    qdr_burst_sram #(.ADDR_W(AW), .WORD_W(WW), .RD_LAT(2)) i_qdr_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid), .cq(cq), .cq_n(cq_n)
    );

    typedef struct packed {
        logic [WW-1:0] w0;
        logic [WW-1:0] w1;
        int            tick;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [2*WW-1:0] mdl [1 << AW];

    int  total = 0, failed = 0;
    int  tick_cnt = 0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;
    int  widx = 0;
    logic [WW-1:0] last_data = '0;

    always @(posedge clk) if (rst_n) tick_cnt <= tick_cnt + 1;

    task automatic check(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one full cycle (K edge then K-bar edge), called at a falling edge
    task automatic cyc(input bit rd, input logic [AW-1:0] ra, input bit wr,
                       input logic [AW-1:0] wa, input logic [WW-1:0] d0,
                       input logic [WW-1:0] d1, input string tag);
        exp_t e;
        rd_sel = rd; wr_sel = wr; addr = ra; wr_data = d0;
        if (rd) begin
            e.w0 = mdl[ra][WW-1:0];
            e.w1 = mdl[ra][2*WW-1:WW];
            e.tick = tick_cnt;
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        @(posedge clk); @(negedge clk);
        rd_sel = 1'b1; wr_sel = 1'b1;   // R3: selects on a K-bar edge are ignored
        addr = wa; wr_data = d1;
        if (wr) mdl[wa] = {d1, d0};
        @(posedge clk); @(negedge clk);
        rd_sel = 1'b0; wr_sel = 1'b0;
    endtask

    // monitor: scoreboard compare away from the active edge
    always @(negedge clk) begin
        if (mon_on && !done) begin
            // R9 echo clocks follow the edge kind
            check(cq == ((tick_cnt - 1) % 2 == 0) && cq_n == !cq, "R9 echo clock", {17'b0, cq}, {17'b0, cq_n});
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected rd_valid", rd_data, '0);
                end else if (widx == 0) begin
                    check(rd_data == exp_q[0].w0, {tag_q[0], " word0 (R5)"}, rd_data, exp_q[0].w0);
                    check(tick_cnt - 1 == exp_q[0].tick + 4, {tag_q[0], " latency R4"},
                          WW'(tick_cnt - 1), WW'(exp_q[0].tick + 4));
                    widx = 1;
                end else begin
                    check(rd_data == exp_q[0].w1, {tag_q[0], " word1 (R5)"}, rd_data, exp_q[0].w1);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                    widx = 0;
                end
                last_data = rd_data;
            end else begin
                check(rd_data == last_data, "R8 hold when idle", rd_data, last_data);
                check(widx == 0, "R5/R11 missing word1", {17'b0, rd_valid}, 18'd1);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failed++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        // R1 reset state
        check(rd_valid == 1'b0, "R1 rd_valid in reset", {17'b0, rd_valid}, '0);
        check(rd_data == '0, "R1 rd_data in reset", rd_data, '0);
        check(cq == 1'b0 && cq_n == 1'b1, "R1 echo in reset", {16'b0, cq, cq_n}, 18'b01);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R2 writes
        for (int i = 0; i < 4; i++)
            cyc(1'b0, 8'hFF, 1'b1, AW'(i), WW'(18'h1000 + i), WW'(18'h2A000 + i), "R2 write");
        // R3 R4 R11 back-to-back reads
        for (int i = 0; i < 4; i++)
            cyc(1'b1, AW'(i), 1'b0, 8'h77, 18'h3FFFF, 18'h3FFFF, "R11 back-to-back read");
        // R7 read right after a write, still buffered
        cyc(1'b0, 8'h00, 1'b1, 8'h10, 18'h0ABCD, 18'h12345, "R7 setup");
        cyc(1'b1, 8'h10, 1'b1, 8'h11, 18'h00111, 18'h00222, "R7 forward pending write");
        cyc(1'b1, 8'h11, 1'b0, 8'h00, 18'h0, 18'h0, "R7 forward second write");
        // R6 read and write one address in the same cycle
        cyc(1'b1, 8'h01, 1'b1, 8'h01, 18'h15555, 18'h2AAAA, "R6 same-cycle read old");
        cyc(1'b1, 8'h01, 1'b0, 8'h00, 18'h0, 18'h0, "R6 read new afterwards");
        // R10 write select low leaves memory alone
        cyc(1'b0, 8'h00, 1'b0, 8'h02, 18'h3DEAD, 18'h3BEEF, "R10 setup");
        cyc(1'b0, 8'h00, 1'b0, 8'h02, 18'h3DEAD, 18'h3BEEF, "R10 setup");
        cyc(1'b1, 8'h02, 1'b0, 8'h00, 18'h0, 18'h0, "R10 unchanged after unselected write");
        // consecutive writes to one address, newest wins
        cyc(1'b0, 8'h00, 1'b1, 8'h20, 18'h00AAA, 18'h00BBB, "R2 overwrite");
        cyc(1'b0, 8'h00, 1'b1, 8'h20, 18'h00CCC, 18'h00DDD, "R2 overwrite");
        cyc(1'b0, 8'h00, 1'b0, 8'h00, 18'h0, 18'h0, "idle");
        cyc(1'b1, 8'h20, 1'b0, 8'h00, 18'h0, 18'h0, "R2 R7 newest write wins");
        cyc(1'b1, 8'h03, 1'b0, 8'h00, 18'h0, 18'h0, "R6 R3 committed data");
        // drain
        for (int i = 0; i < 6; i++) cyc(1'b0, 8'h00, 1'b0, 8'h00, 18'h0, 18'h0, "drain");
        check(exp_q.size() == 0, "R4 all reads returned", WW'(exp_q.size()), '0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule